// File: doc/BRIEF.md
# Mixed-Decay Chopper Sequencer

The block sequences the four switches of one H-bridge winding in a constant-current stepper drive. A free-running oscillator supplies one-cycle ticks, and a fixed number of ticks makes up one chopping period. Each period starts by charging the winding in the direction set by the direction input. When the synchronized current comparator reports that the set current is reached, the block changes to slow decay. During the last ticks of the period the bridge is in fast decay, which returns the coil energy to the supply.

An enable input and a run gate take the bridge out of operation at once. A direction change restarts the period. The block never switches straight from one switch pattern to another: it always inserts one all-off system-clock cycle between them. The comparator is blanked for a set number of system-clock cycles after charging starts, so that switching spikes do not trip it.

Top module: `mixdecay_chopper`

## Requirements
- R1: With the defaults, one chopping period lasts 8 oscillator ticks. With a steady direction and both gates high, successive entries into charge are exactly 8 tick intervals apart.
- R2: Charge mode reports mode_o = 2'b01. With dir_i = 0 it turns on hs_a_o and ls_b_o. With dir_i = 1 it turns on hs_b_o and ls_a_o. All other switches are off.
- R3: After a qualified comparator trip during charge, the bridge enters slow decay: mode_o = 2'b10, ls_a_o and ls_b_o on, both high sides off, in either direction. It stays there until fast decay.
- R4: The tick index of a period runs from 0 to 7. Indices 5, 6 and 7 (the last 3 ticks) are fast decay, mode_o = 2'b11. With dir_i = 0 this turns on hs_b_o and ls_a_o. With dir_i = 1 it turns on hs_a_o and ls_b_o.
- R5: While en_i or run_i is low, all four gate outputs are 0 and mode_o = 2'b00 in the same cycle. The period restarts from tick 0, so charge is applied at the first clock edge after both gates return high.
- R6: A change of dir_i forces the bridge off at the next clock edge and restarts the tick index at 0. Charge in the new direction follows one edge later, and fast decay cannot begin until at least 4 full tick intervals have passed.
- R7: The comparator is ignored for BLANK_CYC system-clock cycles after charge is applied. With a comparator held high, charge lasts BLANK_CYC + 2 cycles.
- R8: trip_i passes through two synchronizer flops. If it rises after blanking has ended, charge is still shown after the third edge, all-off after the fourth, and slow decay after the fifth.
- R9: A high side and a low side on the same leg are never on together. Between any two different switch patterns, one cycle with all switches off and mode_o = 2'b00 is inserted.
- R10: If the comparator does not trip during a period, the bridge goes from charge to fast decay (through the dead cycle) and never enters slow decay.
- R11: While rst_ni is low, all gate outputs are 0 and mode_o = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator tick |
| dir_i | input | 1 | Current direction through the winding |
| en_i | input | 1 | Bridge enable; low turns all switches off |
| run_i | input | 1 | Run/fault gate; low turns all switches off |
| trip_i | input | 1 | Asynchronous comparator flag, high when set current is reached |
| hs_a_o | output | 1 | High-side switch, leg A |
| ls_a_o | output | 1 | Low-side switch, leg A |
| hs_b_o | output | 1 | High-side switch, leg B |
| ls_b_o | output | 1 | Low-side switch, leg B |
| mode_o | output | 2 | Applied mode: 00 off, 01 charge, 10 slow, 11 fast |

## Verification
The enable and run gates act in the same cycle as the stimulus. A direction change shows as all-off after one edge and as charge after two. A comparator rise reaches the outputs as all-off after four edges, and a held comparator gives a charge run of BLANK_CYC + 2 cycles. Inputs are driven on the falling clock edge, and the outputs are sampled 1 ns later against a per-cycle bench model that advances once per step. Each directed check therefore counts whole steps from the stimulus to the exact cycle where the change is due. Random stimulus toggles the comparator, direction and gates, and every cycle is compared.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CHARGE = 2'b01,
    MODE_SLOW   = 2'b10,
    MODE_FAST   = 2'b11
  } bridge_mode_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_set_t;
endpackage

// File: rtl/mdc_sync.sv
module mdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdc_period.sv
module mdc_period #(
  parameter int TICKS_PER_PERIOD = 8,
  parameter int FAST_TICKS       = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  input  logic dir_i,
  output logic restart_o,
  output logic dir_chg_o,
  output logic fast_o
);
  localparam int CNT_W      = (TICKS_PER_PERIOD > 2) ? $clog2(TICKS_PER_PERIOD) : 1;
  localparam int FAST_START = TICKS_PER_PERIOD - FAST_TICKS;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TICKS_PER_PERIOD - 1);
  localparam logic [CNT_W-1:0] FAST_IDX = CNT_W'(FAST_START);

  logic [CNT_W-1:0] tick_idx_q;
  logic             dir_q;

  assign dir_chg_o = dir_i != dir_q;
  assign restart_o = !active_i || dir_chg_o || (tick_i && tick_idx_q == LAST_IDX);
  assign fast_o    = tick_idx_q >= FAST_IDX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_idx_q <= '0;
      dir_q      <= 1'b0;
    end else begin
      dir_q <= dir_i;
      if (restart_o)   tick_idx_q <= '0;
      else if (tick_i) tick_idx_q <= tick_idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdc_decide.sv
module mdc_decide
  import mdc_pkg::*;
#(
  parameter int BLANK_CYC = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         dir_chg_i,
  input  logic         restart_i,
  input  logic         fast_i,
  input  logic         trip_i,
  input  bridge_mode_e app_mode_i,
  output bridge_mode_e tgt_mode_o
);
  localparam int BW = $clog2(BLANK_CYC + 2);
  localparam logic [BW-1:0] BLANK_MAX = BW'(BLANK_CYC);

  logic [BW-1:0] blank_q;
  logic          tripped_q;
  logic          blank_done;
  logic          trip_ok;

  assign blank_done = blank_q == BLANK_MAX;
  assign trip_ok    = (app_mode_i == MODE_CHARGE) && blank_done && trip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q   <= '0;
      tripped_q <= 1'b0;
    end else begin
      if (app_mode_i != MODE_CHARGE) blank_q <= '0;
      else if (!blank_done)          blank_q <= blank_q + 1'b1;
      if (restart_i)    tripped_q <= 1'b0;
      else if (trip_ok) tripped_q <= 1'b1;
    end
  end

  always_comb begin
    if (!active_i || dir_chg_i) tgt_mode_o = MODE_OFF;
    else if (fast_i)            tgt_mode_o = MODE_FAST;
    else if (tripped_q)         tgt_mode_o = MODE_SLOW;
    else                        tgt_mode_o = MODE_CHARGE;
  end
endmodule

// File: rtl/mdc_bridge.sv
module mdc_bridge
  import mdc_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  bridge_mode_e tgt_mode_i,
  input  logic         tgt_dir_i,
  output bridge_mode_e app_mode_o,
  output gate_set_t    gates_o,
  output logic [1:0]   mode_o
);
  bridge_mode_e app_mode_q;
  logic         app_dir_q;
  gate_set_t    raw;

  // any pattern change passes through one all-off cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_mode_q <= MODE_OFF;
      app_dir_q  <= 1'b0;
    end else if (app_mode_q == MODE_OFF) begin
      app_mode_q <= tgt_mode_i;
      app_dir_q  <= tgt_dir_i;
    end else if (tgt_mode_i != app_mode_q || tgt_dir_i != app_dir_q) begin
      app_mode_q <= MODE_OFF;
    end
  end

  always_comb begin
    raw = '0;
    unique case (app_mode_q)
      MODE_CHARGE: begin
        raw.hs_a = !app_dir_q;
        raw.ls_b = !app_dir_q;
        raw.hs_b = app_dir_q;
        raw.ls_a = app_dir_q;
      end
      MODE_SLOW: begin
        raw.ls_a = 1'b1;
        raw.ls_b = 1'b1;
      end
      MODE_FAST: begin
        raw.hs_b = !app_dir_q;
        raw.ls_a = !app_dir_q;
        raw.hs_a = app_dir_q;
        raw.ls_b = app_dir_q;
      end
      default: raw = '0;
    endcase
  end

  assign app_mode_o = app_mode_q;
  assign gates_o    = active_i ? raw : '0;
  assign mode_o     = active_i ? app_mode_q : MODE_OFF;
endmodule

// File: rtl/mixdecay_chopper.sv
module mixdecay_chopper
  import mdc_pkg::*;
#(
  parameter int TICKS_PER_PERIOD = 8,
  parameter int FAST_TICKS       = 3,
  parameter int BLANK_CYC        = 30,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       dir_i,
  input  logic       en_i,
  input  logic       run_i,
  input  logic       trip_i,
  output logic       hs_a_o,
  output logic       ls_a_o,
  output logic       hs_b_o,
  output logic       ls_b_o,
  output logic [1:0] mode_o
);
  logic         active;
  logic         trip_s;
  logic         restart;
  logic         dir_chg;
  logic         fast;
  bridge_mode_e tgt_mode;
  bridge_mode_e app_mode;
  gate_set_t    gates;

  assign active = en_i && run_i;

  mdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_i),
    .q_o   (trip_s)
  );

  mdc_period #(
    .TICKS_PER_PERIOD(TICKS_PER_PERIOD),
    .FAST_TICKS      (FAST_TICKS)
  ) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (osc_tick_i),
    .active_i (active),
    .dir_i    (dir_i),
    .restart_o(restart),
    .dir_chg_o(dir_chg),
    .fast_o   (fast)
  );

  mdc_decide #(.BLANK_CYC(BLANK_CYC)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .dir_chg_i (dir_chg),
    .restart_i (restart),
    .fast_i    (fast),
    .trip_i    (trip_s),
    .app_mode_i(app_mode),
    .tgt_mode_o(tgt_mode)
  );

  mdc_bridge u_bridge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .tgt_mode_i(tgt_mode),
    .tgt_dir_i (dir_i),
    .app_mode_o(app_mode),
    .gates_o   (gates),
    .mode_o    (mode_o)
  );

  assign hs_a_o = gates.hs_a;
  assign ls_a_o = gates.ls_a;
  assign hs_b_o = gates.hs_b;
  assign ls_b_o = gates.ls_b;
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       run_i,
  input logic       hs_a_o,
  input logic       ls_a_o,
  input logic       hs_b_o,
  input logic       ls_b_o,
  input logic [1:0] mode_o
);
  logic [3:0] g;
  assign g = {hs_a_o, ls_a_o, hs_b_o, ls_b_o};

  p_no_shoot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o));

  p_dead_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g != 4'b0 && $past(g) != 4'b0) |-> (g == $past(g) && mode_o == $past(mode_o)));

  p_off_when_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && run_i) |-> (g == 4'b0 && mode_o == 2'b00));

  p_slow_pattern_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> g == 4'b0101);

  p_charge_pattern_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b01 |-> (g == 4'b1001 || g == 4'b0110));

  p_fast_pattern_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b11 |-> ($countones(g) == 2 && (g == 4'b1001 || g == 4'b0110)));

  p_off_pattern_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b00 |-> g == 4'b0);
endmodule

bind mixdecay_chopper mdc_checker u_mdc_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .run_i (run_i),
  .hs_a_o(hs_a_o),
  .ls_a_o(ls_a_o),
  .hs_b_o(hs_b_o),
  .ls_b_o(ls_b_o),
  .mode_o(mode_o)
);

// File: tb/mixdecay_chopper_tb_top.sv
module mixdecay_chopper_tb_top;
  localparam int TICKS = 8;
  localparam int TAIL  = 3;
  localparam int BLANK = 30;
  localparam int GAP   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick = 1'b0, dir = 1'b0, en = 1'b1, run = 1'b1, trip = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b;
  logic [1:0] mode;

  always #5 clk = ~clk;

  mixdecay_chopper dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick), .dir_i(dir),
    .en_i(en), .run_i(run), .trip_i(trip),
    .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b), .mode_o(mode)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int gap_ctr = 0;
  int obs_mode = 0, prev_obs = 0;
  logic [3:0] obs_g;
  // reference model state
  int m_s1 = 0, m_s2 = 0, m_dq = 0, m_cnt = 0, m_trip = 0, m_blank = 0, m_mode = 0, m_dir = 0;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_gates(int md, int dr);
    case (md)
      1: return dr ? 4'b0110 : 4'b1001;
      2: return 4'b0101;
      3: return dr ? 4'b1001 : 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  // one cycle: drive tick, observe, advance model; called at falling edge
  task automatic step();
    int act, dchg, rst_p, fst, tgt, tset;
    int n_cnt, n_trip, n_blank;
    string req;
    osc_tick = (gap_ctr == GAP-1);
    gap_ctr = (gap_ctr == GAP-1) ? 0 : gap_ctr + 1;
    #1;
    act = (en && run) ? 1 : 0;
    prev_obs = obs_mode;
    obs_mode = int'(mode);
    obs_g = {hs_a, ls_a, hs_b, ls_b};
    if (!act) req = "R5";
    else case (m_mode)
      1: req = "R2";
      2: req = "R3";
      3: req = "R4";
      default: req = "R9";
    endcase
    check(req, int'(obs_g), act ? int'(exp_gates(m_mode, m_dir)) : 0);
    check(req, obs_mode, act ? m_mode : 0);
    check("R9", int'((hs_a & ls_a) | (hs_b & ls_b)), 0);
    // model advance
    dchg  = (int'(dir) != m_dq);
    rst_p = (!act || dchg || (osc_tick && m_cnt == TICKS-1));
    fst   = (m_cnt >= TICKS - TAIL);
    tgt   = (!act || dchg) ? 0 : fst ? 3 : m_trip ? 2 : 1;
    tset  = (m_mode == 1 && m_blank == BLANK && m_s2 == 1);
    n_cnt   = rst_p ? 0 : (osc_tick ? m_cnt + 1 : m_cnt);
    n_trip  = rst_p ? 0 : (m_trip | tset);
    n_blank = (m_mode == 1) ? ((m_blank == BLANK) ? BLANK : m_blank + 1) : 0;
    if (m_mode == 0) begin
      m_mode = tgt; m_dir = int'(dir);
    end else if (tgt != m_mode || int'(dir) != m_dir) begin
      m_mode = 0;
    end
    m_cnt = n_cnt; m_trip = n_trip; m_blank = n_blank;
    m_s2 = m_s1; m_s1 = int'(trip); m_dq = int'(dir);
    @(negedge clk);
  endtask

  task automatic wait_charge_entry();
    do step(); while (!(obs_mode == 1 && prev_obs != 1));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int len, slow_n, fast_n, t0, t1;
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);
    #1;
    // R11: reset holds outputs off even with gates high
    check("R11", int'({hs_a, ls_a, hs_b, ls_b}), 0);
    check("R11", int'(mode), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 / R10: period length and no slow decay without a trip
    wait_charge_entry();
    wait_charge_entry();
    len = 0; slow_n = 0; fast_n = 0;
    do begin
      step(); len++;
      if (obs_mode == 2) slow_n++;
      if (obs_mode == 3) fast_n++;
    end while (!(obs_mode == 1 && prev_obs != 1));
    check("R1", len, TICKS*GAP);
    check("R10", slow_n, 0);
    check("R10", (fast_n > 0) ? 1 : 0, 1);

    // R7 / R3: comparator held high -> charge lasts BLANK+2, dead, then slow
    trip = 1'b1;
    repeat (3) step();
    wait_charge_entry();
    len = 1;
    forever begin
      step();
      if (obs_mode == 1) len++; else break;
    end
    check("R7", len, BLANK+2);
    check("R9", obs_mode, 0);
    step();
    check("R3", obs_mode, 2);
    check("R3", int'(obs_g), 4'b0101);
    trip = 1'b0;

    // R8: synchronizer latency after blanking
    wait_charge_entry();
    repeat (BLANK+5) step();
    trip = 1'b1;
    step();
    step(); step(); step();
    check("R8", obs_mode, 1);
    step();
    check("R8", obs_mode, 0);
    step();
    check("R8", obs_mode, 2);
    trip = 1'b0;

    // R6: direction change restarts period
    wait_charge_entry();
    repeat (50) step();
    dir = 1'b1;
    step();
    step();
    check("R6", obs_mode, 0);
    step();
    check("R6", obs_mode, 1);
    check("R6", int'(obs_g), 4'b0110);
    len = 0;
    do begin step(); len++; end while (obs_mode != 3);
    check("R6", (len > 4*GAP) ? 1 : 0, 1);

    // R5: enable and run gate act immediately, period restarts
    wait_charge_entry();
    repeat (10) step();
    en = 1'b0;
    step();
    check("R5", int'(obs_g), 0);
    check("R5", obs_mode, 0);
    repeat (5) step();
    en = 1'b1;
    step();
    step();
    check("R5", obs_mode, 1);
    repeat (20) step();
    run = 1'b0;
    step();
    check("R5", int'(obs_g), 0);
    run = 1'b1;
    step();
    step();
    check("R5", obs_mode, 1);

    // random phase
    t0 = 0;
    for (int i = 0; i < 9000; i++) begin
      if ($urandom % 40 == 0) trip = ~trip;
      if ($urandom % 700 == 0) dir = ~dir;
      if (en && ($urandom % 900 == 0)) en = 1'b0;
      else if (!en && ($urandom % 15 == 0)) en = 1'b1;
      if (run && ($urandom % 1100 == 0)) run = 1'b0;
      else if (!run && ($urandom % 10 == 0)) run = 1'b1;
      step();
      if (obs_mode == 2) t0++;
    end
    t1 = (t0 > 0) ? 1 : 0;
    check("R3", t1, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule